// File: doc/BRIEF.md
# Quad Channel Serial Word Deserializer

This block takes a bit-serial stream from a two-channel digital down-converter. Each frame carries four 24-bit two's complement samples: the in-phase (I) and quadrature (Q) values of channel A and of channel B. The block counts bits from a frame-sync marker, rebuilds the 96-bit frame, splits it into its four fields and keeps one of them. Which field is kept depends on a channel select and a phase mode.

The phase mode chooses I only, Q only, or alternating phases. In alternating mode, successive stored words take turns between the I and Q samples of the chosen channel. Both phases share one record, so each phase gets half of it.

Each kept word goes out with a one-cycle write strobe and an address into a sample memory of 2^ADDR_W words (32,768 by default). When the final location has been written, a done flag rises. The block then ignores frames until a start pulse re-arms the capture.

Top module: `iq_frame_deser`

## Requirements
- R1: After reset, wr_en_o and done_o are low, the first stored word goes to address 0, and alternation begins with I.
- R2: A frame begins on a bit where ser_sync_i and ser_valid_i are both high, and spans exactly 96 bits taken while ser_valid_i is high. Cycles with ser_valid_i low do not advance framing. Bits that arrive outside a frame, with no sync to start one, are ignored.
- R3: The first bit received is the MSB of channel A I. Fields follow in the order A-I, A-Q, B-I, B-Q, each 24 bits long and sent MSB first. wr_data_o carries the selected field unchanged.
- R4: chan_sel_i = 0 selects channel A and chan_sel_i = 1 selects channel B.
- R5: phase_mode_i = 2'b00 stores the I field and 2'b01 stores the Q field of the selected channel.
- R6: phase_mode_i = 2'b10 or 2'b11 stores I and Q alternately, one word per frame, starting with I after reset or start_i. Each phase therefore fills half the record (16K words each by default).
- R7: wr_en_o is high for exactly one cycle, in the cycle after the clock edge that samples the 96th bit. wr_data_o and wr_addr_o are valid in that same cycle.
- R8: Store addresses count up from 0 by one per stored word. A full capture holds 2^ADDR_W words (32,768 by default).
- R9: A sync arriving before 96 bits have been counted discards the partial frame and starts a new frame at that bit.
- R10: done_o rises in the same cycle as the write to the last address (all ones). From then on no write occurs and done_o stays high until start_i.
- R11: A start_i pulse clears done_o, returns the next address to 0 and resets alternation to I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Re-arm a capture |
| ser_bit_i | input | 1 | Serial data bit |
| ser_valid_i | input | 1 | Serial bit qualifier |
| ser_sync_i | input | 1 | Marks the first bit of a frame |
| chan_sel_i | input | 1 | Channel select (0 = A, 1 = B) |
| phase_mode_i | input | 2 | 00 = I, 01 = Q, 1x = alternate |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | 24 | Stored sample |
| done_o | output | 1 | Capture complete |

## Verification
The only result with a latency is the write. Its strobe, data and address are registered at the edge that samples the 96th valid bit, so they are due one cycle later. Inputs are driven on the falling edge. Each frame task therefore checks its outputs at the first falling edge after the last bit, and checks at the next falling edge that the strobe has dropped. done_o is checked in the same cycle as the write to the final address. start_i takes effect at the next rising edge, so its clearing of done_o is read at the falling edge that follows. Frames that must be ignored (unsynced, partial, or after done) are checked at the cycle where their write would have been due, and again through the address of the next accepted word.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef enum logic [1:0] {
    PM_I_ONLY = 2'b00,
    PM_Q_ONLY = 2'b01,
    PM_ALT    = 2'b10,
    PM_ALT_B  = 2'b11
  } phase_mode_e;

  function automatic logic mode_is_alt(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/iqd_frame_shifter.sv
module iqd_frame_shifter #(
  parameter int FRAME_W = 96,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_i,
  input  logic               valid_i,
  input  logic               sync_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_ok_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               in_frame_q;
  logic               last_bit;

  assign last_bit   = valid_i && !sync_i && in_frame_q && (cnt_q == CNT_W'(FRAME_W-1));
  assign frame_o    = {sh_q[FRAME_W-2:0], bit_i};
  assign frame_ok_o = last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (valid_i) begin
      if (sync_i) begin
        // sync restarts framing, partial frame dropped
        sh_q       <= {sh_q[FRAME_W-2:0], bit_i};
        cnt_q      <= CNT_W'(1);
        in_frame_q <= 1'b1;
      end else if (in_frame_q) begin
        sh_q <= {sh_q[FRAME_W-2:0], bit_i};
        if (last_bit) begin
          cnt_q      <= '0;
          in_frame_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W-1));

  // R7
  frame_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |=> !frame_ok_o);

  // R9
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sync_i) |=> (in_frame_q && cnt_q == CNT_W'(1)));
endmodule

// File: rtl/iqd_field_picker.sv
module iqd_field_picker
  import iqd_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int NUM_CH   = 2,
  localparam int NUM_F   = NUM_CH * 2,
  localparam int FRAME_W = SAMPLE_W * NUM_F,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [FRAME_W-1:0]  frame_i,
  input  logic                store_i,
  input  logic [CH_W-1:0]     chan_sel_i,
  input  logic [1:0]          mode_i,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [SAMPLE_W-1:0] fields [NUM_F];
  logic                tog_q;
  logic                ph_sel;
  logic [CH_W:0]       idx;

  // field 0 is the first on the wire
  for (genvar g = 0; g < NUM_F; g++) begin : g_fld
    assign fields[g] = frame_i[FRAME_W-1-g*SAMPLE_W -: SAMPLE_W];
  end

  always_comb begin
    unique case (phase_mode_e'(mode_i))
      PM_I_ONLY: ph_sel = 1'b0;
      PM_Q_ONLY: ph_sel = 1'b1;
      default:   ph_sel = tog_q;
    endcase
  end

  assign idx    = {chan_sel_i, ph_sel};
  assign word_o = fields[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             tog_q <= 1'b0;
    else if (start_i)                        tog_q <= 1'b0;
    else if (store_i && mode_is_alt(mode_i)) tog_q <= ~tog_q;
  end

  // R6
  alt_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && mode_is_alt(mode_i) && !start_i) |=> (tog_q != $past(tog_q)));

  // R11
  start_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !tog_q);
endmodule

// File: rtl/iqd_store_ctrl.sv
module iqd_store_ctrl #(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              store_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;

  assign addr_o = addr_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (store_i) begin
      addr_q <= addr_q + ADDR_W'(1);
      if (&addr_q) done_q <= 1'b1;
    end
  end

  // R8
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !start_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> done_q);
endmodule

// File: rtl/iq_frame_deser.sv
module iq_frame_deser #(
  parameter int SAMPLE_W = 24,
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 15,
  localparam int FRAME_W = SAMPLE_W * NUM_CH * 2,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                ser_bit_i,
  input  logic                ser_valid_i,
  input  logic                ser_sync_i,
  input  logic [CH_W-1:0]     chan_sel_i,
  input  logic [1:0]          phase_mode_i,
  output logic                wr_en_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [SAMPLE_W-1:0] wr_data_o,
  output logic                done_o
);
  logic [FRAME_W-1:0]  frame;
  logic                frame_ok;
  logic                store;
  logic [SAMPLE_W-1:0] word;
  logic [ADDR_W-1:0]   next_addr;
  logic                done;

  iqd_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (ser_bit_i),
    .valid_i    (ser_valid_i),
    .sync_i     (ser_sync_i),
    .frame_o    (frame),
    .frame_ok_o (frame_ok)
  );

  // frame completing during start or after done is dropped
  assign store = frame_ok && !done && !start_i;

  iqd_field_picker #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .frame_i    (frame),
    .store_i    (store),
    .chan_sel_i (chan_sel_i),
    .mode_i     (phase_mode_i),
    .word_o     (word)
  );

  iqd_store_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .store_i (store),
    .addr_o  (next_addr),
    .done_o  (done)
  );

  assign done_o = done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= store;
      if (store) begin
        wr_addr_o <= next_addr;
        wr_data_o <= word;
      end
    end
  end

  // R7
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  // R10
  no_wr_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !wr_en_o);

  // R11
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !wr_en_o));
endmodule

// File: tb/sim_iq_frame_deser.sv
module sim_iq_frame_deser;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sbit = 1'b0;
  logic        svalid = 1'b0;
  logic        ssync = 1'b0;
  logic [0:0]  chan = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        wr_en;
  logic [AW-1:0] wr_addr;
  logic [23:0] wr_data;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  int  exp_addr = 0;
  bit  exp_done = 1'b0;
  bit  exp_tog = 1'b0;

  always #5 clk = ~clk;

  iq_frame_deser #(.SAMPLE_W(24), .NUM_CH(2), .ADDR_W(AW)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .ser_bit_i    (sbit),
    .ser_valid_i  (svalid),
    .ser_sync_i   (ssync),
    .chan_sel_i   (chan),
    .phase_mode_i (mode),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .done_o       (done)
  );

  function automatic logic [23:0] fld(input int n, input int k);
    return 24'((n * 4 + k) * 32'h031CB7) ^ 24'h800001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive n_bits of frame n; gap idle cycles between bits
  task automatic drive_bits(input int n, input int n_bits, input bit use_sync, input int gap);
    logic [95:0] fr;
    fr = {fld(n, 0), fld(n, 1), fld(n, 2), fld(n, 3)};
    for (int i = 0; i < n_bits; i++) begin
      @(negedge clk);
      sbit   = fr[95 - i];
      svalid = 1'b1;
      ssync  = use_sync && (i == 0);
      if (gap > 0 && i < n_bits - 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          svalid = 1'b0;
          ssync  = 1'b0;
          sbit   = ~sbit;
        end
      end
    end
    @(negedge clk);
    svalid = 1'b0;
    ssync  = 1'b0;
  endtask

  // full frame; checks the write due one cycle after the last bit edge
  task automatic send_frame(input int n, input bit use_sync, input int gap, input string tag);
    int sel;
    drive_bits(n, 96, use_sync, gap);
    if (use_sync && !exp_done) begin
      sel = (mode == 2'b00) ? 0 : (mode == 2'b01) ? 1 : int'(exp_tog);
      chk("R7 wr_en at frame end", 32'(wr_en), 32'd1);
      chk(tag, 32'(wr_data), 32'(fld(n, int'(chan) * 2 + sel)));
      chk("R8 address", 32'(wr_addr), 32'(exp_addr));
      if (exp_addr == DEPTH - 1) exp_done = 1'b1;
      chk("R10 done with final write", 32'(done), 32'(exp_done));
      if (mode[1]) exp_tog = ~exp_tog;
      exp_addr = (exp_addr + 1) % DEPTH;
      @(negedge clk);
      chk("R7 single cycle strobe", 32'(wr_en), 32'd0);
    end else begin
      chk(tag, 32'(wr_en), 32'd0);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_addr = 0;
    exp_done = 1'b0;
    exp_tog  = 1'b0;
    chk("R11 start clears done", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 wr_en in reset", 32'(wr_en), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_en after reset", 32'(wr_en), 32'd0);
  endtask

  task automatic t_select();
    mode = 2'b00; chan = 1'b0;
    send_frame(1, 1'b1, 0, "R3 R4 R5 A-I field");
    send_frame(2, 1'b1, 0, "R3 R5 A-I second");
    mode = 2'b01; chan = 1'b1;
    send_frame(3, 1'b1, 0, "R4 R5 B-Q field");
    mode = 2'b00; chan = 1'b1;
    send_frame(4, 1'b1, 0, "R4 R5 B-I field");
    mode = 2'b01; chan = 1'b0;
    send_frame(5, 1'b1, 0, "R3 R5 A-Q field");
  endtask

  task automatic t_framing();
    mode = 2'b00; chan = 1'b0;
    send_frame(6, 1'b1, 2, "R2 valid gaps hold framing");
    send_frame(7, 1'b0, 0, "R2 unsynced bits ignored");
    drive_bits(8, 40, 1'b1, 0);
    chk("R9 partial frame no write", 32'(wr_en), 32'd0);
    send_frame(9, 1'b1, 0, "R9 restart keeps new frame");
  endtask

  task automatic t_alt_and_done();
    pulse_start();
    mode = 2'b10; chan = 1'b1;
    for (int f = 0; f < DEPTH; f++) begin
      send_frame(20 + f, 1'b1, 0, "R6 alternating phase");
    end
    chk("R10 done after fill", 32'(done), 32'd1);
    send_frame(60, 1'b1, 0, "R10 frame ignored after done");
    chk("R10 done stays", 32'(done), 32'd1);
    pulse_start();
    mode = 2'b11; chan = 1'b0;
    send_frame(61, 1'b1, 0, "R11 R6 restart at I address 0");
    send_frame(62, 1'b1, 0, "R6 second phase Q");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_select();
    t_framing();
    t_alt_and_done();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule